// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the controller-side sender of a time-slotted serial audio link. It runs on the link bit clock and drives two wires: a frame marker (`link_sync`) and one serial data line (`link_sdata`). Each frame lasts 256 bit clocks. The frame opens with a 16-bit tag slot. Twelve 20-bit data slots follow, and every slot is sent most significant bit first.

A frame's contents arrive on a parallel valid/ready load port. The inputs are a frame-valid flag, twelve per-slot valid flags, twelve 20-bit payloads and a sample width that applies to every slot of that frame. The block raises `frm_ready` for exactly one bit clock at the start of each frame. A transfer takes place only in that cycle, and only if `frm_valid` is high. The captured word goes into a shadow shift register, so changes on the load port during transmission leave the frame in flight untouched.

Back-pressure goes one way only. The link never stalls. If the source misses the ready window, the next frame is sent as all zeros, and its tag slot is zero too. `frm_valid` has no effect while `frm_ready` is low. The block also counts the frames it starts.

Top module: `aud_frame_tx`

## Requirements
- R1: `frm_ready` is high for exactly one cycle in every 256. The first window opens in the first cycle after reset is released, and the next one 256 cycles later.
- R2: `link_sync` rises on the clock edge that ends a ready cycle and stays high for exactly 16 consecutive bit clocks.
- R3: On the edge after `link_sync` rises, `link_sdata` starts the tag slot. The first bit is the frame-valid flag. The next 12 bits are the valid flags of slots 1 to 12, in that order (slot k is `frm_slot_vld[k-1]`). The last 3 bits are 0.
- R4: After the tag slot come slots 1 to 12, each 20 bits, MSB first. The payload of slot k is `frm_payload[(k-1)*20 +: 20]`.
- R5: Every bit of a slot whose valid flag is 0 is sent as 0, whatever its payload.
- R6: In a valid slot, only the top `frm_width` bits of the payload are sent and the remaining low-order bits are 0. A width of 0, or of more than 20, means all 20 bits are sent.
- R7: A frame is captured only when `frm_valid` and `frm_ready` are both high. If no capture takes place, the whole next frame, tag slot included, is sent as 0.
- R8: Changes to any load-port input after the capture cycle do not alter the frame being sent.
- R9: `frame_cnt` increases by one on every frame start edge and wraps around at its width.
- R10: While the synchronous reset `rst` is high, `link_sync`, `link_sdata`, `frm_ready` and `frame_cnt` are 0. After release the frame sequence restarts from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; every output changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | Source offers a frame |
| frm_ready | output | 1 | One-cycle capture window at frame start |
| frm_frame_vld | input | 1 | Frame-valid flag sent as the first tag bit |
| frm_slot_vld | input | NUM_SLOTS | Valid flag per data slot, bit 0 = slot 1 |
| frm_payload | input | NUM_SLOTS*SLOT_W | Slot payloads, slot 1 in the low 20 bits |
| frm_width | input | WID_W | Meaningful bits per valid slot (0 = full) |
| link_sync | output | 1 | Frame marker, high during the tag slot |
| link_sdata | output | 1 | Serial data, MSB first |
| frame_cnt | output | CNT_W | Count of frames started |

## Verification
The bench builds the transmitter with the default slot layout (16-bit tag, twelve 20-bit slots, 256-bit frame). It narrows `CNT_W` to 3 so that the frame counter wraps within a run of about fifteen frames. The full frame length is kept, so every bit position is compared against a model frame, including the last bit of each frame, which leaves on the next frame's start edge. The runs also reach the width clamping at 0 and above 20, and a reset that lands in the middle of a frame.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  localparam int DEF_SLOTS  = 12;
  localparam int DEF_SLOT_W = 20;
  localparam int DEF_TAG_W  = 16;

  typedef enum logic {PH_TAG = 1'b0, PH_DATA = 1'b1} link_phase_e;

  // Width requests of zero or beyond the slot size select the full slot.
  function automatic int eff_width(input int req, input int slot_w);
    return (req == 0 || req > slot_w) ? slot_w : req;
  endfunction

endpackage

// File: rtl/aud_tx_seq.sv
module aud_tx_seq #(
  parameter int FRAME_LEN = 256,
  parameter int TAG_W     = 16,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_valid,
  output logic             ready,
  output logic             start,
  output logic             load,
  output logic             sync,
  output logic [CNT_W-1:0] frame_cnt
);
  import aud_tx_pkg::*;

  localparam int POS_W = $clog2(FRAME_LEN);

  logic [POS_W-1:0] cnt;
  link_phase_e      phase_d;

  // cnt == 0: the coming edge opens a new frame
  assign start   = (cnt == '0);
  assign ready   = !rst && start;
  assign load    = ready && frm_valid;
  assign phase_d = (cnt < POS_W'(TAG_W)) ? PH_TAG : PH_DATA;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sync      <= 1'b0;
      frame_cnt <= '0;
    end else begin
      cnt  <= (cnt == POS_W'(FRAME_LEN - 1)) ? '0 : cnt + 1'b1;
      sync <= (phase_d == PH_TAG);
      if (start) frame_cnt <= frame_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/aud_tx_pack.sv
module aud_tx_pack #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 20,
  parameter int TAG_W     = 16,
  parameter int WID_W     = 5,
  parameter int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W
) (
  input  logic                        frame_vld,
  input  logic [NUM_SLOTS-1:0]        slot_vld,
  input  logic [NUM_SLOTS*SLOT_W-1:0] payload,
  input  logic [WID_W-1:0]            width,
  output logic [FRAME_LEN-1:0]        frame_bits
);
  import aud_tx_pkg::*;

  localparam int PAD_W = TAG_W - 1 - NUM_SLOTS;

  logic [SLOT_W-1:0] keep;
  int                width_eff;

  always_comb begin
    width_eff = eff_width(int'(width), SLOT_W);
    for (int i = 0; i < SLOT_W; i++) keep[i] = (i >= SLOT_W - width_eff);
  end

  // Bit FRAME_LEN-1 leaves first.
  assign frame_bits[FRAME_LEN-1] = frame_vld;

  generate
    if (PAD_W > 0) begin : g_pad
      assign frame_bits[FRAME_LEN-TAG_W +: PAD_W] = '0;
    end
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign frame_bits[FRAME_LEN-2-s] = slot_vld[s];
      assign frame_bits[FRAME_LEN-1-TAG_W-s*SLOT_W -: SLOT_W] =
        slot_vld[s] ? (payload[s*SLOT_W +: SLOT_W] & keep) : '0;
    end
  endgenerate

endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift #(
  parameter int FRAME_LEN = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 load,
  input  logic [FRAME_LEN-1:0] frame_bits,
  output logic                 sdata
);

  logic [FRAME_LEN-1:0] shadow;

  // The start edge still sends the previous frame's last bit, then reloads.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      sdata  <= 1'b0;
    end else begin
      sdata <= shadow[FRAME_LEN-1];
      if (start) shadow <= load ? frame_bits : '0;
      else       shadow <= {shadow[FRAME_LEN-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/aud_frame_tx.sv
module aud_frame_tx #(
  parameter int NUM_SLOTS = aud_tx_pkg::DEF_SLOTS,
  parameter int SLOT_W    = aud_tx_pkg::DEF_SLOT_W,
  parameter int TAG_W     = aud_tx_pkg::DEF_TAG_W,
  parameter int CNT_W     = 16,
  parameter int WID_W     = $clog2(SLOT_W + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frm_valid,
  output logic                        frm_ready,
  input  logic                        frm_frame_vld,
  input  logic [NUM_SLOTS-1:0]        frm_slot_vld,
  input  logic [NUM_SLOTS*SLOT_W-1:0] frm_payload,
  input  logic [WID_W-1:0]            frm_width,
  output logic                        link_sync,
  output logic                        link_sdata,
  output logic [CNT_W-1:0]            frame_cnt
);

  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;

  logic                 start;
  logic                 load;
  logic [FRAME_LEN-1:0] frame_bits;

  aud_tx_seq #(
    .FRAME_LEN(FRAME_LEN),
    .TAG_W    (TAG_W),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .frm_valid(frm_valid),
    .ready    (frm_ready),
    .start    (start),
    .load     (load),
    .sync     (link_sync),
    .frame_cnt(frame_cnt)
  );

  aud_tx_pack #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W),
    .TAG_W    (TAG_W),
    .WID_W    (WID_W),
    .FRAME_LEN(FRAME_LEN)
  ) u_pack (
    .frame_vld (frm_frame_vld),
    .slot_vld  (frm_slot_vld),
    .payload   (frm_payload),
    .width     (frm_width),
    .frame_bits(frame_bits)
  );

  aud_tx_shift #(
    .FRAME_LEN(FRAME_LEN)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .load      (load),
    .frame_bits(frame_bits),
    .sdata     (link_sdata)
  );

endmodule

// File: rtl/aud_frame_tx_chk.sv
module aud_frame_tx_chk #(
  parameter int FRAME_LEN = 256,
  parameter int TAG_W     = 16,
  parameter int NUM_SLOTS = 12,
  parameter int CNT_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ready,
  input logic             sync,
  input logic             sdata,
  input logic [CNT_W-1:0] frame_cnt
);

  localparam int POS_W = $clog2(FRAME_LEN);

  // Independent frame-position tracker
  logic [POS_W-1:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst) chk_cnt <= '0;
    else     chk_cnt <= (chk_cnt == POS_W'(FRAME_LEN - 1)) ? '0 : chk_cnt + 1'b1;
  end

  a_r1_ready_period: assert property (@(posedge clk) disable iff (rst)
    ready == (chk_cnt == '0));

  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  a_r2_sync_after_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(sync) |-> $past(ready));

  a_r2_sync_window: assert property (@(posedge clk) disable iff (rst)
    sync == (chk_cnt >= POS_W'(1) && chk_cnt <= POS_W'(TAG_W)));

  a_r3_tag_pad: assert property (@(posedge clk) disable iff (rst)
    (chk_cnt >= POS_W'(NUM_SLOTS + 3) && chk_cnt <= POS_W'(TAG_W + 1)) |-> !sdata);

  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ready)) |-> frame_cnt == $past(frame_cnt) + 1'b1);

  a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(ready)) |-> $stable(frame_cnt));

  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!sync && !sdata && frame_cnt == '0));

endmodule

bind aud_frame_tx aud_frame_tx_chk #(
  .FRAME_LEN(FRAME_LEN),
  .TAG_W    (TAG_W),
  .NUM_SLOTS(NUM_SLOTS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ready    (frm_ready),
  .sync     (link_sync),
  .sdata    (link_sdata),
  .frame_cnt(frame_cnt)
);

// File: tb/tb_aud_frame_tx.sv
`timescale 1ns/1ps
module tb_aud_frame_tx;

  localparam int NS = 12;
  localparam int SW = 20;
  localparam int TW = 16;
  localparam int CW = 3;
  localparam int WW = 5;
  localparam int FL = TW + NS * SW;

  logic           clk = 1'b0;
  logic           rst;
  logic           frm_valid;
  logic           frm_ready;
  logic           frm_frame_vld;
  logic [NS-1:0]  frm_slot_vld;
  logic [NS*SW-1:0] frm_payload;
  logic [WW-1:0]  frm_width;
  logic           link_sync;
  logic           link_sdata;
  logic [CW-1:0]  frame_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [FL-1:0] prev_exp = '0;
  logic [CW-1:0] exp_cnt  = '0;

  always #2.5 clk = ~clk;

  aud_frame_tx #(
    .NUM_SLOTS(NS), .SLOT_W(SW), .TAG_W(TW), .CNT_W(CW), .WID_W(WW)
  ) dut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_frame_vld(frm_frame_vld), .frm_slot_vld(frm_slot_vld),
    .frm_payload(frm_payload), .frm_width(frm_width),
    .link_sync(link_sync), .link_sdata(link_sdata), .frame_cnt(frame_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Expected frame, position 0 at bit FL-1
  function automatic logic [FL-1:0] model(input bit fv, input logic [NS-1:0] sv,
                                          input logic [NS*SW-1:0] pay, input int w);
    int we = (w == 0 || w > SW) ? SW : w;
    logic [FL-1:0] r = '0;
    r[FL-1] = fv;
    for (int s = 0; s < NS; s++) begin
      r[FL-2-s] = sv[s];
      if (sv[s])
        for (int b = 0; b < we; b++)
          r[FL-1-TW-s*SW-b] = pay[s*SW + SW-1-b];
    end
    return r;
  endfunction

  task automatic scramble();
    frm_valid     = 1'($urandom());
    frm_frame_vld = 1'($urandom());
    frm_slot_vld  = NS'($urandom());
    frm_width     = WW'($urandom_range(0, 31));
    for (int s = 0; s < NS; s++) frm_payload[s*SW +: SW] = SW'($urandom());
  endtask

  // Entered at a negedge where the capture window is expected open.
  task automatic run_frame(input bit take, input bit fv, input logic [NS-1:0] sv,
                           input logic [NS*SW-1:0] pay, input int w, input string req);
    logic [FL-1:0] exp;
    int bad_pos = -1;
    logic bad_act = 1'b0, bad_exp = 1'b0;
    int sync_bad = -1;
    int rdy_bad  = -1;
    chk(frm_ready === 1'b1, "R1", "ready at frame start", 64'(frm_ready), 64'd1);
    frm_valid     = take;
    frm_frame_vld = fv;
    frm_slot_vld  = sv;
    frm_payload   = pay;
    frm_width     = WW'(w);
    exp = take ? model(fv, sv, pay, w) : '0;
    for (int j = 0; j < FL; j++) begin
      logic eb;
      @(negedge clk);
      if (j == 0) begin
        exp_cnt = exp_cnt + 1'b1;
        chk(frame_cnt === exp_cnt, "R9", "frame count", 64'(frame_cnt), 64'(exp_cnt));
        scramble(); // R8: load port churns during transmission
      end
      eb = (j == 0) ? prev_exp[0] : exp[FL-j];
      if (link_sdata !== eb && bad_pos < 0) begin
        bad_pos = j; bad_act = link_sdata; bad_exp = eb;
      end
      if (link_sync !== (j < TW) && sync_bad < 0) sync_bad = j;
      if (j < FL-1 && frm_ready !== 1'b0 && rdy_bad < 0) rdy_bad = j;
    end
    chk(bad_pos < 0, req, $sformatf("serial data at step %0d", bad_pos),
        64'(bad_act), 64'(bad_exp));
    chk(sync_bad < 0, "R2", $sformatf("sync window at step %0d", sync_bad),
        64'(link_sync), 64'(sync_bad < TW));
    chk(rdy_bad < 0, "R1", $sformatf("ready closed at step %0d", rdy_bad), 64'd1, 64'd0);
    prev_exp = exp;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [NS*SW-1:0] pay;
    void'($urandom(32'h5eed_0a17));
    rst = 1'b1;
    frm_valid = 1'b0; frm_frame_vld = 1'b0; frm_slot_vld = '0;
    frm_payload = '0; frm_width = '0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(link_sync === 1'b0 && link_sdata === 1'b0, "R10", "outputs low in reset",
        64'({link_sync, link_sdata}), 64'd0);
    chk(frm_ready === 1'b0 && frame_cnt === '0, "R10", "ready/count in reset",
        64'({frm_ready, frame_cnt}), 64'd0);
    rst = 1'b0;
    #0.1;

    for (int s = 0; s < NS; s++) pay[s*SW +: SW] = SW'(32'hA5C3F + s * 32'h1111);
    run_frame(1, 1, '1, pay, 20, "R3/R4 all valid");
    run_frame(1, 0, '0, '1, 20, "R5 no valid slots");
    run_frame(1, 1, 12'hA5A, pay, 20, "R5 mixed valid");
    run_frame(1, 1, 12'h010, '1, 20, "R3 single slot");
    run_frame(1, 1, '1, '1, 1, "R6 width one");
    run_frame(1, 1, '1, pay, 16, "R6 width sixteen");
    run_frame(1, 1, '1, '1, 0, "R6 width zero is full");
    run_frame(1, 1, '1, pay, 24, "R6 width above slot is full");
    run_frame(0, 1, '1, '1, 20, "R7 no capture gives empty frame");
    for (int k = 0; k < 6; k++) begin
      logic [NS*SW-1:0] rp;
      for (int s = 0; s < NS; s++) rp[s*SW +: SW] = SW'($urandom());
      run_frame(1, 1'($urandom()), NS'($urandom()), rp, int'($urandom_range(0, 24)),
                "R8 random frame");
    end

    // R10: reset in mid-frame restarts the sequence
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(link_sync === 1'b0 && link_sdata === 1'b0 && frame_cnt === '0, "R10",
        "mid-frame reset clears outputs", 64'({link_sync, link_sdata, frame_cnt}), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    #0.1;
    prev_exp = '0;
    exp_cnt  = '0;
    run_frame(1, 1, 12'h801, pay, 12, "R10 frame after reset");

    done = 1'b1;
    summary();
  end

endmodule